// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-clock static memory meant to sit behind a processor or cache controller as a burst-capable secondary cache store. Every control, address and write-data input is taken on the rising clock edge. A transfer opens with one of two address strobes: one driven from the processor side and one from the cache-controller side. After that, a two-bit burst counter on the lowest address bits produces the following words of the aligned group of four. The counter steps only while the advance input is high. A static order pin chooses between interleaved order and linear wrap-around order.

Read data leaves through an output register, so a word whose address is taken at one edge is on `data_out` after the next edge. Writes can cover any set of byte lanes under a byte-write enable, and a global-write input overrides the lane selects. Three chip enables act as a qualifier on every strobe. An output enable masks the valid flag without any clock involved. A sleep input stops all activity, and the block needs a wake-up interval before it accepts work again. The word count is set by the address-width parameter: 15 address bits give 32768 words.

Top module: `burst_sram`

## Requirements
- R1: After reset, `data_valid` is low and `data_out` is zero.
- R2: A read started at clock edge E drives the word onto `data_out` with `data_valid` high after edge E+1. Every following non-write cycle of the same burst delivers one more word, one edge later.
- R3: With `burst_interleave` high, burst word k (k = 0..3) is at the start address with its two low bits replaced by (start[1:0] XOR k).
- R4: With `burst_interleave` low, burst word k is at the start address with its two low bits replaced by (start[1:0] + k) mod 4. The upper bits never change.
- R5: In a burst cycle with no strobe, `advance` high steps the counter before that cycle's access, and `advance` low repeats the current address.
- R6: When `wr_byte_en` is high, `byte_sel[i]` writes data bits 8i+7:8i (lane 0 is bits 7:0, lane 3 is bits 31:24). When `wr_byte_en` is low, `byte_sel` has no effect and the cycle is a read.
- R7: `wr_global` high writes all four lanes, whatever `wr_byte_en` and `byte_sel` are.
- R8: A strobe opens a burst only when all of `chip_en0`, `chip_en1` and `chip_en2` are high. Otherwise the block is deselected: nothing is written, and no read data is made valid.
- R9: `start_proc` takes priority over `start_ctrl`. A cycle started by `start_proc` is always a read whatever the write inputs say. A write to that address is done in the next cycle with `advance` low.
- R10: A cycle started by `start_ctrl` with a write request writes `data_in` to `addr` at that edge.
- R11: `data_valid` equals the registered valid flag ANDed with `out_en`, and needs no clock edge.
- R12: While `sleep` is high, and during the first three edges after it falls, strobes and writes are ignored and `data_valid` is low after each such edge. The fourth edge after `sleep` falls is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address taken on a strobe |
| start_proc | input | 1 | Processor-side address strobe (read start, top priority) |
| start_ctrl | input | 1 | Controller-side address strobe (read or write start) |
| advance | input | 1 | Step the burst counter in a continuation cycle |
| burst_interleave | input | 1 | 1: XOR burst order, 0: linear wrap order |
| chip_en0 | input | 1 | Chip enable, active high |
| chip_en1 | input | 1 | Chip enable, active high |
| chip_en2 | input | 1 | Chip enable, active high |
| wr_global | input | 1 | Write all byte lanes |
| wr_byte_en | input | 1 | Allow the per-lane selects |
| byte_sel | input | DATA_W/8 | Per-lane write select |
| data_in | input | DATA_W | Write data |
| out_en | input | 1 | Output enable, masks `data_valid` |
| sleep | input | 1 | Power-down request |
| data_out | output | DATA_W | Registered read data |
| data_valid | output | 1 | Read data valid, gated by `out_en` |

## Verification
A burst counter that starts in the wrong state or takes a step it should not take gives a wrong word on `data_out` one edge after the address was used. This shows up on the first burst beat, and the bench predicts every beat from its own memory image. A wrong wake-up count or a stuck deselect shows at the ports a little later: a write that should land is lost or applied, or `data_valid` rises in the wrong cycle. The readback two edges later exposes it. Lane-mask errors show only when a partly written word is read back, so the bench tracks which bytes it knows and checks those bytes.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;

    typedef enum logic [2:0] {
        CYC_ASLEEP,
        CYC_START_P,
        CYC_START_C,
        CYC_CONTINUE,
        CYC_IDLE
    } cyc_e;

    // Low two address bits of burst beat cnt starting from start.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       interleave);
        logic [1:0] r;
        if (interleave) r = start ^ cnt;
        else            r = start + cnt;
        return r;
    endfunction

endpackage

// File: rtl/bsram_ctrl.sv
`timescale 1ns/1ps
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int WAKE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic start_proc,
    input  logic start_ctrl,
    input  logic advance,
    input  logic ce_ok,
    input  logic wr_req,
    output logic load,
    output logic step,
    output logic wr_en,
    output logic rd_go,
    output logic awake
);
    localparam int WW = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic [WW-1:0] wake;
        logic          sel;
        logic          pend;
    } ctrl_t;

    ctrl_t st_q, st_d;
    cyc_e  cyc;

    always_comb begin
        st_d  = st_q;
        load  = 1'b0;
        step  = 1'b0;
        wr_en = 1'b0;
        awake = !sleep && (st_q.wake == '0);
        if (sleep || st_q.wake != '0)      cyc = CYC_ASLEEP;
        else if (start_proc)               cyc = CYC_START_P;
        else if (start_ctrl)               cyc = CYC_START_C;
        else if (st_q.sel)                 cyc = CYC_CONTINUE;
        else                               cyc = CYC_IDLE;

        case (cyc)
            CYC_ASLEEP: begin
                st_d.wake = sleep ? WW'(WAKE_CYC) : st_q.wake - 1'b1;
                st_d.sel  = 1'b0;
                st_d.pend = 1'b0;
            end
            CYC_START_P: begin
                load      = ce_ok;
                st_d.sel  = ce_ok;
                st_d.pend = ce_ok;
            end
            CYC_START_C: begin
                load      = ce_ok;
                wr_en     = ce_ok && wr_req;
                st_d.sel  = ce_ok;
                st_d.pend = ce_ok && !wr_req;
            end
            CYC_CONTINUE: begin
                step      = advance;
                wr_en     = wr_req;
                st_d.pend = !wr_req;
            end
            default: begin
                st_d.pend = 1'b0;
            end
        endcase
        rd_go = st_q.pend && awake;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_WAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wake != '0) |-> (!load && !wr_en && !rd_go)); // R12
    AST_PROC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        start_proc |-> !wr_en); // R9
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_ok && (start_proc || start_ctrl)) |=> !st_q.sel && !st_q.pend); // R8

endmodule

// File: rtl/bsram_burst.sv
`timescale 1ns/1ps
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_in,
    input  logic          interleave,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] eff_addr
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [1:0]    cnt;
    } burst_t;

    burst_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base = addr_in;
            st_d.cnt  = 2'd0;
        end else if (step) begin
            st_d.cnt  = st_q.cnt + 2'd1;
        end
        cur_addr = {st_q.base[AW-1:2], burst_low(st_q.base[1:0], st_q.cnt, interleave)};
        eff_addr = {st_d.base[AW-1:2], burst_low(st_d.base[1:0], st_d.cnt, interleave)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_GROUP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])); // R4
    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (interleave != $past(interleave)) || (cur_addr != $past(cur_addr))); // R5
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> (interleave != $past(interleave)) || (cur_addr == $past(cur_addr))); // R5

endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
module bsram_array #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW/8-1:0] wr_mask,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] dout,
    output logic          dvalid
);
    localparam int DEPTH = 1 << AW;
    localparam int NB    = DW / 8;

    typedef struct packed {
        logic [DW-1:0] dout;
        logic          valid;
    } out_t;

    logic [DW-1:0] mem_q [DEPTH];
    out_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < NB; i++) begin
                if (wr_mask[i]) mem_q[wr_addr][i*8 +: 8] <= wr_data[i*8 +: 8];
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_go;
        if (rd_go) st_d.dout = mem_q[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout   = st_q.dout;
    assign dvalid = st_q.valid;

    AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |-> $past(rd_go)); // R2
    AST_WRITE_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_mask != '0)); // R6

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int WAKE_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                start_proc,
    input  logic                start_ctrl,
    input  logic                advance,
    input  logic                burst_interleave,
    input  logic                chip_en0,
    input  logic                chip_en1,
    input  logic                chip_en2,
    input  logic                wr_global,
    input  logic                wr_byte_en,
    input  logic [DATA_W/8-1:0] byte_sel,
    input  logic [DATA_W-1:0]   data_in,
    input  logic                out_en,
    input  logic                sleep,
    output logic [DATA_W-1:0]   data_out,
    output logic                data_valid
);
    localparam int NB = DATA_W / 8;

    logic [NB-1:0]     lane_mask;
    logic              ce_ok, wr_req;
    logic              load, step, wr_en, rd_go, awake;
    logic [ADDR_W-1:0] cur_addr, eff_addr;
    logic              valid_q;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_mask[i] = wr_global | (wr_byte_en & byte_sel[i]);
    end

    assign ce_ok  = chip_en0 & chip_en1 & chip_en2;
    assign wr_req = |lane_mask;

    bsram_ctrl #(.WAKE_CYC(WAKE_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep(sleep),
        .start_proc(start_proc), .start_ctrl(start_ctrl), .advance(advance),
        .ce_ok(ce_ok), .wr_req(wr_req),
        .load(load), .step(step), .wr_en(wr_en), .rd_go(rd_go), .awake(awake)
    );

    bsram_burst #(.AW(ADDR_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .addr_in(addr), .interleave(burst_interleave),
        .cur_addr(cur_addr), .eff_addr(eff_addr)
    );

    bsram_array #(.AW(ADDR_W), .DW(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(lane_mask),
        .wr_addr(eff_addr), .wr_data(data_in),
        .rd_go(rd_go), .rd_addr(cur_addr),
        .dout(data_out), .dvalid(valid_q)
    );

    assign data_valid = valid_q & out_en;

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !valid_q); // R12
    AST_ASLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |-> !wr_en); // R12

endmodule

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic start_proc = 0, start_ctrl = 0, advance = 0, burst_interleave = 1;
    logic chip_en0 = 1, chip_en1 = 1, chip_en2 = 1;
    logic wr_global = 0, wr_byte_en = 0;
    logic [3:0] byte_sel = '0;
    logic [DW-1:0] data_in = '0;
    logic out_en = 1, sleep = 0;
    logic [DW-1:0] data_out;
    logic data_valid;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .DATA_W(DW), .WAKE_CYC(3)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .start_proc(start_proc),
        .start_ctrl(start_ctrl), .advance(advance), .burst_interleave(burst_interleave),
        .chip_en0(chip_en0), .chip_en1(chip_en1), .chip_en2(chip_en2),
        .wr_global(wr_global), .wr_byte_en(wr_byte_en), .byte_sel(byte_sel),
        .data_in(data_in), .out_en(out_en), .sleep(sleep),
        .data_out(data_out), .data_valid(data_valid)
    );

    // reference model
    logic [DW-1:0] mem [DEPTH];
    logic [3:0]    kn  [DEPTH];
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_sel = 0, m_pend = 0, m_valid = 0;
    int            m_wake = 0;
    logic [DW-1:0] m_dout = '0;
    logic [3:0]    m_dkn = 4'hF;

    function automatic logic [AW-1:0] baddr(logic [AW-1:0] b, logic [1:0] c, logic il);
        logic [1:0] lo;
        lo = il ? (b[1:0] ^ c) : (b[1:0] + c);
        return {b[AW-1:2], lo};
    endfunction

    task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic awake, ce, wreq, ld, stp, wen;
        logic [3:0] mask;
        logic [AW-1:0] cur, eff;
        awake = !sleep && (m_wake == 0);
        cur = baddr(m_base, m_cnt, burst_interleave);
        if (m_pend && awake) begin
            m_valid = 1; m_dout = mem[cur]; m_dkn = kn[cur];
        end else m_valid = 0;
        mask = wr_global ? 4'hF : (wr_byte_en ? byte_sel : 4'h0);
        wreq = (mask != 0);
        ce = chip_en0 && chip_en1 && chip_en2;
        ld = 0; stp = 0; wen = 0;
        if (sleep) begin m_wake = 3; m_sel = 0; m_pend = 0; end
        else if (m_wake != 0) begin m_wake--; m_sel = 0; m_pend = 0; end
        else if (start_proc) begin ld = ce; m_sel = ce; m_pend = ce; end
        else if (start_ctrl) begin ld = ce; m_sel = ce; wen = ce && wreq; m_pend = ce && !wreq; end
        else if (m_sel) begin stp = advance; wen = wreq; m_pend = !wreq; end
        else m_pend = 0;
        if (ld) begin m_base = addr; m_cnt = 0; end
        else if (stp) m_cnt = m_cnt + 1;
        eff = baddr(m_base, m_cnt, burst_interleave);
        if (wen) begin
            for (int i = 0; i < 4; i++) begin
                if (mask[i]) begin
                    mem[eff][i*8 +: 8] = data_in[i*8 +: 8];
                    kn[eff][i] = 1'b1;
                end
            end
        end
    endtask

    function automatic logic [DW-1:0] kmask(logic [3:0] k);
        logic [DW-1:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{k[i]}};
        return m;
    endfunction

    task automatic tick(string req);
        @(posedge clk);
        model_edge();
        #1;
        check(data_valid == (m_valid && out_en), req, {31'd0, data_valid}, {31'd0, m_valid && out_en});
        if (m_valid)
            check(((data_out ^ m_dout) & kmask(m_dkn)) == 0, req, data_out, m_dout);
        @(negedge clk);
    endtask

    task automatic idle_in();
        start_proc = 0; start_ctrl = 0; advance = 0;
        wr_global = 0; wr_byte_en = 0; byte_sel = 0;
        chip_en0 = 1; chip_en1 = 1; chip_en2 = 1;
    endtask

    task automatic wr_word(logic [AW-1:0] a, logic [DW-1:0] d, string req);
        idle_in(); start_ctrl = 1; addr = a; wr_global = 1; data_in = d;
        tick(req);
        idle_in(); start_proc = 1; chip_en1 = 0; tick(req); idle_in();
    endtask

    task automatic rd_word(logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
        idle_in(); start_proc = 1; addr = a; tick("R2");
        idle_in(); tick("R2");
        d = data_out; v = data_valid;
        start_proc = 1; chip_en1 = 0; tick("R8"); idle_in();
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic v;
        logic [1:0] ord;
        for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; kn[i] = 4'h0; end
        void'($urandom(32'd4242));
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        #0;
        check(data_valid == 0, "R1", {31'd0, data_valid}, 0);
        check(data_out == 0, "R1", data_out, 0);
        tick("R1");

        // R10: controller-strobe writes of a group of four
        for (int i = 0; i < 4; i++) wr_word(AW'(10'h40 + i), 32'hA000_0000 + i, "R10");

        // R3 / R4: burst from 0x41 in both orders
        for (int il = 1; il >= 0; il--) begin
            burst_interleave = il[0];
            idle_in(); start_proc = 1; addr = 10'h41; tick("R2");
            for (int k = 0; k < 4; k++) begin
                idle_in(); advance = (k < 3);
                tick(il ? "R3" : "R4");
                ord = il ? (2'd1 ^ 2'(k)) : (2'd1 + 2'(k));
                check(data_valid && data_out == 32'hA000_0000 + ord, il ? "R3" : "R4",
                      data_out, 32'hA000_0000 + ord);
            end
            idle_in(); start_proc = 1; chip_en2 = 0; tick("R8");
        end
        burst_interleave = 1;
        // R5: advance low repeats the address
        idle_in(); start_proc = 1; addr = 10'h42; tick("R5");
        idle_in(); tick("R5");
        idle_in(); tick("R5");
        check(data_valid && data_out == 32'hA000_0002, "R5", data_out, 32'hA000_0002);
        idle_in(); start_proc = 1; chip_en0 = 0; tick("R8"); idle_in();

        // R6: lane writes
        wr_word(10'h50, 32'h0, "R6");
        idle_in(); start_ctrl = 1; addr = 10'h50; wr_byte_en = 1; byte_sel = 4'b0101;
        data_in = 32'hAABB_CCDD; tick("R6");
        idle_in(); start_ctrl = 1; addr = 10'h50; wr_byte_en = 0; byte_sel = 4'hF;
        data_in = 32'h1111_1111; tick("R6");
        idle_in(); tick("R6");
        check(data_valid && data_out == 32'h00BB_00DD, "R6", data_out, 32'h00BB_00DD);
        idle_in(); start_proc = 1; chip_en0 = 0; tick("R8"); idle_in();
        // R7: global write overrides lanes
        idle_in(); start_ctrl = 1; addr = 10'h50; wr_global = 1; wr_byte_en = 1;
        byte_sel = 4'b0001; data_in = 32'h1234_5678; tick("R7"); idle_in();
        rd_word(10'h50, d, v);
        check(v && d == 32'h1234_5678, "R7", d, 32'h1234_5678);

        // R9: processor strobe ignores write, next cycle writes
        wr_word(10'h60, 32'h0, "R9");
        idle_in(); start_proc = 1; start_ctrl = 1; addr = 10'h60; wr_global = 1;
        data_in = 32'hDEAD_0001; tick("R9");
        idle_in(); wr_global = 1; data_in = 32'hBEEF_0002; tick("R9");
        idle_in(); start_proc = 1; chip_en0 = 0; tick("R9"); idle_in();
        rd_word(10'h60, d, v);
        check(v && d == 32'hBEEF_0002, "R9", d, 32'hBEEF_0002);

        // R8: deselected write is dropped
        idle_in(); start_ctrl = 1; addr = 10'h60; wr_global = 1; chip_en1 = 0;
        data_in = 32'h0BAD_0BAD; tick("R8"); idle_in();
        tick("R8");
        check(data_valid == 0, "R8", {31'd0, data_valid}, 0);
        rd_word(10'h60, d, v);
        check(v && d == 32'hBEEF_0002, "R8", d, 32'hBEEF_0002);

        // R11: output enable masks valid at once
        idle_in(); start_proc = 1; addr = 10'h60; tick("R11");
        idle_in(); tick("R11");
        out_en = 0; #1;
        check(data_valid == 0, "R11", {31'd0, data_valid}, 0);
        out_en = 1; #1;
        check(data_valid == 1, "R11", {31'd0, data_valid}, 1);
        @(negedge clk);
        idle_in(); start_proc = 1; chip_en0 = 0; tick("R8"); idle_in();

        // R12: sleep and three-edge wake-up
        for (int i = 0; i < 4; i++) wr_word(AW'(10'h70 + i), 32'h0, "R12");
        sleep = 1; idle_in(); start_ctrl = 1; addr = 10'h74; wr_global = 1;
        data_in = 32'h5;
        tick("R12"); tick("R12");
        check(data_valid == 0, "R12", {31'd0, data_valid}, 0);
        sleep = 0;
        for (int i = 0; i < 4; i++) begin
            idle_in(); start_ctrl = 1; addr = AW'(10'h70 + i); wr_global = 1;
            data_in = 32'hC0DE_0000 + i; tick("R12");
        end
        idle_in(); start_proc = 1; chip_en0 = 0; tick("R12"); idle_in();
        for (int i = 0; i < 4; i++) begin
            rd_word(AW'(10'h70 + i), d, v);
            check(v && d == ((i == 3) ? 32'hC0DE_0003 : 32'h0), "R12", d,
                  (i == 3) ? 32'hC0DE_0003 : 32'h0);
        end

        // random mix checked against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 15);
            start_proc = (r == 0);
            start_ctrl = (r == 1) || (r == 2);
            advance    = $urandom_range(0, 1);
            chip_en0   = ($urandom_range(0, 15) != 0);
            chip_en1   = ($urandom_range(0, 15) != 0);
            chip_en2   = ($urandom_range(0, 15) != 0);
            wr_global  = ($urandom_range(0, 5) == 0);
            wr_byte_en = ($urandom_range(0, 2) == 0);
            byte_sel   = 4'($urandom);
            data_in    = $urandom;
            out_en     = ($urandom_range(0, 7) != 0);
            sleep      = ($urandom_range(0, 99) == 0);
            addr       = {6'h07, 4'($urandom)};
            if (n % 250 == 0) burst_interleave = $urandom_range(0, 1);
            tick("R2");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule